// File: doc/BRIEF.md
# 100BASE-TX Transmit Line Encoder

This block turns the 4-bit transmit nibbles of a fast Ethernet MAC into the three-level line symbol stream of a 100 Mb/s twisted-pair transmitter. It runs on a single bit-rate clock (125 MHz in use). Once every five clocks it pulses `nib_load` and samples the transmit enable and the data nibble on that edge, which gives the 25 MHz nibble rate. Each sampled nibble, or a control code that the framing logic picks, becomes a 5-bit code group. The group is shifted out one bit per clock. Each bit is XORed with a free-running 11-bit scrambler key and fed to an NRZI stage. An MLT-3 stage then turns the NRZI transitions into a level of -1, 0 or +1.

When no packet is in flight, the block sends the idle code group continuously. On the first sampled nibble with enable high, the start-of-stream pair is sent in place of the first two nibbles of the preamble. After the enable drops, the end-of-stream pair follows, and then idle again. The analog driver, wave shaping and the receive path lie outside this block.

Top module: `tx_line_encoder`

## Requirements
- R1: While `rst_n` is low, `line_lvl` is 0 (2'b00), `nrzi_out` is 0 and `nib_load` is 0. The scrambler state is all ones, the code group being shifted is idle and the framing state is idle.
- R2: After reset is released, `nib_load` is high for exactly one clock in every five, first in the fifth clock (four clocks after release). The inputs are sampled on the rising edge that ends a clock with `nib_load` high.
- R3: With no packet in flight, every code group is idle, value 5'h1F.
- R4: A sampled enable of 1 in the idle framing state starts a packet. The group 5'h18 is sent for that slot and 5'h11 for the next slot, whose nibble and enable are ignored.
- R5: During a packet, each sampled nibble with enable high is sent as its 5-bit code group. In hex the codes for nibbles 0 to F are 1E, 09, 14, 15, 0A, 0B, 0E, 0F, 12, 13, 16, 17, 1A, 1B, 1C, 1D.
- R6: The first sampled enable of 0 during a packet sends 5'h0D. The next slot sends 5'h07 whatever its inputs are, and the framing state then returns to idle. An enable raised in that slot starts no packet.
- R7: Each code group is serialized bit 0 first, one bit per clock. Each serial bit is XORed with a key k = s[10] XOR s[8] of an 11-bit scrambler state s. In every clock, s shifts toward the MSB and k enters at bit 0 (polynomial x^11 + x^9 + 1).
- R8: `nrzi_out` toggles on the edge that ends a clock whose scrambled bit is 1, and holds otherwise.
- R9: `line_lvl` is a 2-bit signed level: 2'b00 = 0, 2'b01 = +1, 2'b11 = -1, and 2'b10 never appears. It changes exactly when `nrzi_out` toggles, stepping through 0, +1, 0, -1 in that cycle. It never moves between +1 and -1 in one step.
- R10: The serial bit sent in the clock after `nib_load` is bit 0 of the group chosen from the inputs sampled at that `nib_load`. The line level shows each serial bit one clock after that bit is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC, sampled when `nib_load` is high |
| txd | input | 4 | Transmit nibble, sampled when `nib_load` is high |
| nib_load | output | 1 | Marks the clock whose closing edge samples `tx_en` and `txd` |
| nrzi_out | output | 1 | NRZI level after scrambling |
| line_lvl | output | 2 | MLT-3 line level, 2-bit signed |

## Verification
Two functions can fall in the same cycle: the framing decision at a group boundary and the end-of-stream sequence. The bench provokes this by raising the enable exactly in the slot where the second end-of-stream group is chosen. It does this once with the enable dropped again afterwards, and once with the enable held so that a new packet starts at once. Both cases are judged on every clock against a bench model that rebuilds the expected code groups, scrambles them and encodes the line levels. A wrongly started packet or a missing idle group therefore shows up as a level mismatch at the exact bit position. Every nibble value is also sent once in a single packet, and packets of one to eleven nibbles are sent as well.

// File: rtl/tle_pkg.sv
package tle_pkg;

   localparam int CG_W  = 5;
   localparam int NIB_W = 4;

   typedef logic [CG_W-1:0]  cg_t;
   typedef logic [NIB_W-1:0] nib_t;

   // Control code groups
   localparam cg_t CG_IDLE = 5'h1F;
   localparam cg_t CG_SSD1 = 5'h18;
   localparam cg_t CG_SSD2 = 5'h11;
   localparam cg_t CG_ESD1 = 5'h0D;
   localparam cg_t CG_ESD2 = 5'h07;

   // Framing state at code-group granularity
   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_SSD2 = 2'd1,
      FR_BODY = 2'd2,
      FR_ESD2 = 2'd3
   } fr_state_e;

   // Signed line levels
   localparam logic [1:0] LVL_ZERO = 2'b00;
   localparam logic [1:0] LVL_POS  = 2'b01;
   localparam logic [1:0] LVL_NEG  = 2'b11;

   function automatic cg_t nib_to_cg(input nib_t n);
      cg_t c;
      case (n)
         4'h0: c = 5'h1E;
         4'h1: c = 5'h09;
         4'h2: c = 5'h14;
         4'h3: c = 5'h15;
         4'h4: c = 5'h0A;
         4'h5: c = 5'h0B;
         4'h6: c = 5'h0E;
         4'h7: c = 5'h0F;
         4'h8: c = 5'h12;
         4'h9: c = 5'h13;
         4'hA: c = 5'h16;
         4'hB: c = 5'h17;
         4'hC: c = 5'h1A;
         4'hD: c = 5'h1B;
         4'hE: c = 5'h1C;
         default: c = 5'h1D;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/tle_framer.sv
module tle_framer
   import tle_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en,
   input  nib_t       txd,
   output logic       nib_load,
   output logic       ser_bit
);

   localparam int CNT_W = $clog2(CG_W);
   localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(CG_W - 1);

   logic [CNT_W-1:0] slot_q;
   cg_t              shift_q;
   cg_t              next_cg;
   fr_state_e        st_q, st_d;

   assign nib_load = (slot_q == SLOT_LAST);
   assign ser_bit  = shift_q[0];

   // Code group selection for the next slot (R3..R6)
   always_comb begin
      next_cg = CG_IDLE;
      st_d    = st_q;
      case (st_q)
         FR_IDLE: begin
            if (tx_en) begin
               next_cg = CG_SSD1;
               st_d    = FR_SSD2;
            end
         end
         FR_SSD2: begin
            next_cg = CG_SSD2;
            st_d    = FR_BODY;
         end
         FR_BODY: begin
            if (tx_en) begin
               next_cg = nib_to_cg(txd);
            end else begin
               next_cg = CG_ESD1;
               st_d    = FR_ESD2;
            end
         end
         default: begin
            next_cg = CG_ESD2;
            st_d    = FR_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q  <= '0;
         shift_q <= CG_IDLE;
         st_q    <= FR_IDLE;
      end else if (nib_load) begin
         slot_q  <= '0;
         shift_q <= next_cg;
         st_q    <= st_d;
      end else begin
         slot_q  <= slot_q + 1'b1;
         shift_q <= {1'b1, shift_q[CG_W-1:1]};
      end
   end

endmodule

// File: rtl/tle_scrambler.sv
module tle_scrambler #(
   parameter int              LFSR_W = 11,
   parameter int              TAP    = 9,
   parameter logic [LFSR_W-1:0] SEED = '1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   initial begin
      assert (TAP > 0 && TAP < LFSR_W)
         else $error("tle_scrambler: tap position out of range");
      assert (SEED != '0)
         else $error("tle_scrambler: seed must be nonzero");
   end

   logic [LFSR_W-1:0] lfsr_q;
   logic              key;

   assign key  = lfsr_q[LFSR_W-1] ^ lfsr_q[TAP-1];
   assign dout = din ^ key;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lfsr_q <= SEED;
      end else begin
         lfsr_q <= {lfsr_q[LFSR_W-2:0], key};
      end
   end

endmodule

// File: rtl/tle_mlt3.sv
module tle_mlt3
   import tle_pkg::*;
#(
   parameter int PH_W = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sbit,
   output logic       nrzi_o,
   output logic [1:0] lvl_o
);

   initial begin
      assert (PH_W == 2)
         else $error("tle_mlt3: four-phase cycle needs a 2-bit phase");
   end

   logic [PH_W-1:0] ph_q;
   logic            nrzi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= '0;
         nrzi_q <= 1'b0;
      end else if (sbit) begin
         ph_q   <= ph_q + 1'b1;
         nrzi_q <= ~nrzi_q;
      end
   end

   assign nrzi_o = nrzi_q;

   always_comb begin
      case (ph_q)
         2'd1:    lvl_o = LVL_POS;
         2'd3:    lvl_o = LVL_NEG;
         default: lvl_o = LVL_ZERO;
      endcase
   end

endmodule

// File: rtl/tx_line_encoder.sv
module tx_line_encoder
   import tle_pkg::*;
#(
   parameter int               LFSR_W    = 11,
   parameter int               LFSR_TAP  = 9,
   parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en,
   input  logic [3:0] txd,
   output logic       nib_load,
   output logic       nrzi_out,
   output logic [1:0] line_lvl
);

   logic ser_bit;
   logic scr_bit;

   tle_framer i_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_en),
      .txd      (txd),
      .nib_load (nib_load),
      .ser_bit  (ser_bit)
   );

   tle_scrambler #(
      .LFSR_W (LFSR_W),
      .TAP    (LFSR_TAP),
      .SEED   (LFSR_SEED)
   ) i_scrambler (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ser_bit),
      .dout  (scr_bit)
   );

   tle_mlt3 i_mlt3 (
      .clk    (clk),
      .rst_n  (rst_n),
      .sbit   (scr_bit),
      .nrzi_o (nrzi_out),
      .lvl_o  (line_lvl)
   );

endmodule

// File: rtl/tle_chk.sv
module tle_chk
   import tle_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       nib_load,
   input logic       nrzi_out,
   input logic [1:0] line_lvl
);

   logic [2:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n || nib_load) gap_q <= '0;
      else                    gap_q <= gap_q + 1'b1;
   end

   // R2
   nib_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nib_load |=> !nib_load);

   // R2
   nib_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nib_load |-> (gap_q == 3'(CG_W - 1)));

   // R9
   lvl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_lvl != 2'b10);

   // R9
   no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((line_lvl == LVL_POS) |=> (line_lvl != LVL_NEG)) and
      ((line_lvl == LVL_NEG) |=> (line_lvl != LVL_POS)));

   // R8
   nrzi_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(nrzi_out) |-> $stable(line_lvl));

   // R9
   lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(nrzi_out) |-> !$stable(line_lvl));

endmodule

bind tx_line_encoder tle_chk i_tle_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .nib_load (nib_load),
   .nrzi_out (nrzi_out),
   .line_lvl (line_lvl)
);

// File: tb/test_tx_line_encoder.sv
module test_tx_line_encoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0;
   logic [3:0] txd = 4'h0;
   logic       nib_load;
   logic       nrzi_out;
   logic [1:0] line_lvl;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   always #5 clk = ~clk;

   tx_line_encoder i_tx_line_encoder (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_en),
      .txd      (txd),
      .nib_load (nib_load),
      .nrzi_out (nrzi_out),
      .line_lvl (line_lvl)
   );

   // stimulus per slot
   bit         st_en[$];
   logic [3:0] st_nib[$];
   // expected serial bits and the requirement each belongs to
   bit         bq[$];
   int         tq[$];

   // bench model state
   logic [10:0] m_lfsr;
   bit          m_nrzi;
   int          m_ph;
   int          m_fr;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // R5 code table
   function automatic logic [4:0] code_of(input logic [3:0] n);
      logic [4:0] t [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                             5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
      return t[n];
   endfunction

   task automatic push_group(input logic [4:0] cg, input int req);
      for (int b = 0; b < 5; b++) begin   // R7: bit 0 first
         bq.push_back(cg[b]);
         tq.push_back(req);
      end
   endtask

   task automatic add_slot(input bit en, input logic [3:0] n);
      st_en.push_back(en);
      st_nib.push_back(n);
   endtask

   task automatic add_idle(input int k);
      for (int i = 0; i < k; i++) add_slot(1'b0, 4'h0);
   endtask

   task automatic add_frame(input int len, input int seed);
      for (int i = 0; i < len; i++) add_slot(1'b1, 4'((seed + i) % 16));
   endtask

   function automatic int exp_lvl(input int ph);
      case (ph % 4)
         1: return 1;
         3: return 3;
         default: return 0;
      endcase
   endfunction

   initial begin
      int lcg = 7;
      // stimulus plan
      add_idle(4);                      // R3
      add_frame(18, 14);                // R5: nibbles 0..F after the two replaced slots
      add_idle(2);
      add_frame(1, 3);                  // R4/R6: single-slot packet
      add_idle(3);
      add_frame(4, 9);                  // R6: enable raised only in the ESD2 slot
      add_slot(1'b0, 4'h0);
      add_slot(1'b1, 4'h5);
      add_idle(3);
      add_frame(3, 2);                  // R6: enable held from ESD2 slot onward
      add_slot(1'b0, 4'h0);
      add_frame(6, 11);
      add_idle(2);
      for (int f = 0; f < 10; f++) begin
         for (int i = 0; i < f + 2; i++) begin
            lcg = (lcg * 37 + 11) % 256;
            add_slot(1'b1, 4'(lcg));
         end
         add_idle(1 + (f % 3));
      end
      add_idle(12);

      // R1: reset state
      repeat (3) @(negedge clk);
      check(line_lvl == 2'b00, "R1 line_lvl", int'(line_lvl), 0);
      check(nrzi_out == 1'b0, "R1 nrzi_out", int'(nrzi_out), 0);
      check(nib_load == 1'b0, "R1 nib_load", int'(nib_load), 0);

      m_lfsr = 11'h7FF;
      m_nrzi = 0;
      m_ph   = 0;
      m_fr   = 0;
      push_group(5'h1F, 1);             // R1: idle group shifted after reset

      rst_n = 1'b1;
      for (int cyc = 0; st_en.size() > 0 || cyc % 5 != 0; cyc++) begin
         bit k, s, cur;
         int req;
         // outputs reflect bits 0..cyc-1
         check(nib_load == (cyc % 5 == 4), "R2 nib_load", int'(nib_load), int'(cyc % 5 == 4));
         check(nrzi_out == m_nrzi, "R8 nrzi_out", int'(nrzi_out), int'(m_nrzi));
         req = (tq.size() > 0) ? tq[0] : 10;
         check(int'(line_lvl) == exp_lvl(m_ph), $sformatf("R%0d/R9/R10 line_lvl", req),
               int'(line_lvl), exp_lvl(m_ph));

         if (nib_load) begin
            bit         en = 1'b0;
            logic [3:0] nb = 4'h0;
            if (st_en.size() > 0) begin
               en = st_en.pop_front();
               nb = st_nib.pop_front();
            end
            tx_en = en;
            txd   = nb;
            case (m_fr)
               0: if (en) begin push_group(5'h18, 4); m_fr = 1; end
                  else push_group(5'h1F, 3);
               1: begin push_group(5'h11, 4); m_fr = 2; end
               2: if (en) push_group(code_of(nb), 5);
                  else begin push_group(5'h0D, 6); m_fr = 3; end
               default: begin push_group(5'h07, 6); m_fr = 0; end
            endcase
         end

         // R7 scrambler, R8 NRZI, R9 MLT-3 for the bit sent this clock
         cur = bq.pop_front();
         void'(tq.pop_front());
         k = m_lfsr[10] ^ m_lfsr[8];
         m_lfsr = {m_lfsr[9:0], k};
         s = cur ^ k;
         if (s) begin
            m_nrzi = ~m_nrzi;
            m_ph   = m_ph + 1;
         end
         @(negedge clk);
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

endmodule